// File: doc/BRIEF.md
# Serial LCD command/data framer

This block turns instruction bytes and display-data bytes from an upstream sequencer into the synchronous three-wire serial frames accepted by a graphic LCD controller. It has a select line, a serial clock and a serial data line. A frame opens with a header byte that carries the register-select and read/write flags. Each payload byte then follows as two bytes, one per nibble. The read/write flag is always "write".

The sequencer issues a request over a valid/ready handshake. A request is either a single instruction byte or the start of a display-data burst. The bytes of a burst arrive on a separate byte stream with a last flag, and they all share the one header. When the final bit has left, the block drops the select and waits a hold-off. The hold-off is given per request in microseconds and converted to system cycles with a clock-frequency parameter. After the hold-off it pulses a done strobe. A new request can be accepted in the same cycle as that strobe.

Top module: `lcd_ser_framer`

## Requirements
- R1: The first byte of every frame is the header `1111_1,RW,RS,0` with RW = 0. This gives 0xF8 for an instruction (req_data_i = 0) and 0xFA for display data (req_data_i = 1).
- R2: Each payload byte B is sent as two bytes. The first is `{B[7:4],4'b0000}` and the second is `{B[3:0],4'b0000}`.
- R3: An instruction frame holds exactly 3 bytes (24 serial clock rises) inside one select window.
- R4: A data burst holds one header, then two bytes for each stream byte up to and including the one flagged last, all in one select window. A 16-byte burst therefore gives 33 bytes. Stalls on the byte stream only stretch the clock-high idle time.
- R5: Bits go MSB first. The serial clock idles high. Data changes only while the clock is low and is sampled on the rising edge. Each low half-period lasts exactly SCLK_DIV system cycles, and each high half-period lasts at least SCLK_DIV.
- R6: The select (lcd_cs_o, active high) is high for the whole frame. It falls only after the high half of the final bit has ended, and the clock is high when it falls.
- R7: done_o is a one-cycle pulse. It arrives exactly N cycles after the select falls, where N = hold_us × CLK_HZ / 1e6. With N = 0 it arrives in the same cycle the select falls.
- R8: req_ready_o is low while a frame or its hold-off is in progress. It is high when idle and in the done cycle. A request accepted in the done cycle raises the select in the very next cycle.
- R9: dat_ready_o is high only while a burst frame is waiting for its next byte. Stream traffic offered at any other time is not taken and starts nothing.
- R10: During and right after reset: select low, clock high, data low, req_ready_o high, dat_ready_o low, done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken |
| req_data_i | input | 1 | 1: display-data burst, 0: single instruction |
| req_cmd_i | input | 8 | Instruction byte (ignored for bursts) |
| req_hold_us_i | input | HOLD_US_W | Post-frame hold-off in microseconds |
| dat_valid_i | input | 1 | Burst byte offered |
| dat_ready_o | output | 1 | Burst byte can be taken |
| dat_byte_i | input | 8 | Burst byte |
| dat_last_i | input | 1 | Marks final byte of the burst |
| done_o | output | 1 | One-cycle completion strobe |
| lcd_cs_o | output | 1 | Serial select, active high |
| lcd_sclk_o | output | 1 | Serial clock, idles high |
| lcd_sdo_o | output | 1 | Serial data, MSB first |

## Verification
The done strobe of one frame and the acceptance of the next request can fall in the same cycle. The ready signal rises in the done cycle, so the select can fall and rise again with only the hold-off between them. The bench issues requests one after another, so each new request waits for ready and lands in the done cycle. This is tried both with a zero hold-off and with a non-zero one. The judgement is made at the ports: the reference marks the cycle where done, valid and ready are all high, then requires the select to be high in the next sample. The bytes of the new frame must decode to the new request.

// File: rtl/lcd_framer_pkg.sv
package lcd_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_NHI,
    ST_NLO,
    ST_WDAT,
    ST_HOLD
  } fr_state_e;

  function automatic logic [7:0] sync_hdr(input logic rs);
    return {5'b11111, 1'b0, rs, 1'b0};
  endfunction

  function automatic logic [7:0] nib_hi(input logic [7:0] b);
    return {b[7:4], 4'b0000};
  endfunction

  function automatic logic [7:0] nib_lo(input logic [7:0] b);
    return {b[3:0], 4'b0000};
  endfunction

endpackage

// File: rtl/lcd_bit_shifter.sv
module lcd_bit_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       last_o,
  output logic       sclk_o,
  output logic       sdo_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic          hi_q;
  logic          busy_q;
  logic          half_end;

  assign half_end = (div_q == DW'(DIV - 1));
  assign last_o   = busy_q && hi_q && half_end && (bit_q == 3'd0);
  assign busy_o   = busy_q;
  assign sclk_o   = !busy_q || hi_q;
  assign sdo_o    = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      hi_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= byte_i;
      bit_q  <= 3'd7;
      div_q  <= '0;
      hi_q   <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (half_end) begin
        div_q <= '0;
        if (!hi_q) begin
          hi_q <= 1'b1;
        end else if (bit_q == 3'd0) begin
          busy_q <= 1'b0;  // keep last bit on sdo while idle
        end else begin
          hi_q  <= 1'b0;
          bit_q <= bit_q - 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  // R5
  sdo_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

endmodule

// File: rtl/lcd_hold_timer.sv
module lcd_hold_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] cycles_i,
  output logic         fire_o
);

  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         fire_q;

  assign fire_o = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (start_i) begin
        if (cycles_i == '0) begin
          fire_q <= 1'b1;
        end else begin
          run_q <= 1'b1;
          cnt_q <= cycles_i - W'(1);
        end
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end

  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);

  // R7
  fire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

endmodule

// File: rtl/lcd_ser_framer.sv
module lcd_ser_framer
  import lcd_framer_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_DIV  = 4,
  parameter int HOLD_US_W = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_data_i,
  input  logic [7:0]           req_cmd_i,
  input  logic [HOLD_US_W-1:0] req_hold_us_i,
  input  logic                 dat_valid_i,
  output logic                 dat_ready_o,
  input  logic [7:0]           dat_byte_i,
  input  logic                 dat_last_i,
  output logic                 done_o,
  output logic                 lcd_cs_o,
  output logic                 lcd_sclk_o,
  output logic                 lcd_sdo_o
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int CPU_W      = $clog2(CYC_PER_US + 1);
  localparam int HCYC_W     = HOLD_US_W + CPU_W;

  fr_state_e             st_q, st_d;
  logic                  rs_q;
  logic [7:0]            pay_q;
  logic                  last_q;
  logic [HOLD_US_W-1:0]  hold_q;

  logic                  sh_ld, sh_busy, sh_last;
  logic [7:0]            sh_byte;
  logic                  fire, acc_req, acc_dat, frame_end;
  logic [HCYC_W-1:0]     hold_cyc;

  assign req_ready_o = (st_q == ST_IDLE) || (st_q == ST_HOLD && fire);
  assign dat_ready_o = (st_q == ST_WDAT);
  assign acc_req     = req_valid_i && req_ready_o;
  assign acc_dat     = dat_valid_i && dat_ready_o;
  assign frame_end   = sh_last && (st_q == ST_NLO) && (!rs_q || last_q);
  assign hold_cyc    = HCYC_W'(hold_q) * HCYC_W'(CYC_PER_US);
  assign lcd_cs_o    = (st_q == ST_SYNC) || (st_q == ST_NHI) ||
                       (st_q == ST_NLO)  || (st_q == ST_WDAT);
  assign done_o      = fire;

  always_comb begin
    st_d    = st_q;
    sh_ld   = 1'b0;
    sh_byte = '0;
    unique case (st_q)
      ST_IDLE: if (acc_req) begin
        sh_ld = 1'b1; sh_byte = sync_hdr(req_data_i); st_d = ST_SYNC;
      end
      ST_SYNC: if (sh_last) begin
        if (rs_q) st_d = ST_WDAT;
        else begin sh_ld = 1'b1; sh_byte = nib_hi(pay_q); st_d = ST_NHI; end
      end
      ST_WDAT: if (acc_dat) begin
        sh_ld = 1'b1; sh_byte = nib_hi(dat_byte_i); st_d = ST_NHI;
      end
      ST_NHI: if (sh_last) begin
        sh_ld = 1'b1; sh_byte = nib_lo(pay_q); st_d = ST_NLO;
      end
      ST_NLO: if (sh_last) st_d = (!rs_q || last_q) ? ST_HOLD : ST_WDAT;
      ST_HOLD: if (fire) begin
        if (acc_req) begin
          sh_ld = 1'b1; sh_byte = sync_hdr(req_data_i); st_d = ST_SYNC;
        end else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rs_q   <= 1'b0;
      pay_q  <= '0;
      last_q <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (acc_req) begin
        rs_q   <= req_data_i;
        pay_q  <= req_cmd_i;
        hold_q <= req_hold_us_i;
      end
      if (acc_dat) begin
        pay_q  <= dat_byte_i;
        last_q <= dat_last_i;
      end
    end
  end

  lcd_bit_shifter #(.DIV(SCLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sh_ld),
    .byte_i (sh_byte),
    .busy_o (sh_busy),
    .last_o (sh_last),
    .sclk_o (lcd_sclk_o),
    .sdo_o  (lcd_sdo_o)
  );

  lcd_hold_timer #(.W(HCYC_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (frame_end),
    .cycles_i (hold_cyc),
    .fire_o   (fire)
  );

  // R5
  load_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_ld |-> (!sh_busy || sh_last));

  // R6
  cs_fall_clk_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_cs_o) |-> (lcd_sclk_o && !sh_busy));

  // R8
  ready_not_framing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_cs_o);

  // R7
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lcd_cs_o);

  // R9
  dat_take_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_dat |=> (lcd_cs_o && !lcd_sclk_o));

endmodule

// File: tb/sim_lcd_ser_framer.sv
module sim_lcd_ser_framer;
  localparam int CLK_HZ = 2_000_000;
  localparam int DIV    = 2;
  localparam int HUS    = 11;
  localparam int CPU    = CLK_HZ / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           req_valid = 1'b0, req_data = 1'b0;
  logic [7:0]     req_cmd = '0;
  logic [HUS-1:0] req_hold = '0;
  logic           dat_valid = 1'b0, dat_last = 1'b0;
  logic [7:0]     dat_byte = '0;
  logic           req_ready, dat_ready, done, cs, sclk, sdo;

  lcd_ser_framer #(.CLK_HZ(CLK_HZ), .SCLK_DIV(DIV), .HOLD_US_W(HUS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_data_i(req_data),
    .req_cmd_i(req_cmd), .req_hold_us_i(req_hold),
    .dat_valid_i(dat_valid), .dat_ready_o(dat_ready), .dat_byte_i(dat_byte),
    .dat_last_i(dat_last), .done_o(done),
    .lcd_cs_o(cs), .lcd_sclk_o(sclk), .lcd_sdo_o(sdo)
  );

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  int len_q[$];
  int hold_q[$];

  logic prev_cs = 1'b0, prev_sclk = 1'b1, prev_sdo = 1'b0;
  int low_run = 0, hi_run = 100, bitn = 0, frame_bytes = 0, done_due = -1;
  logic [7:0] acc = '0;
  logic chk_b2b = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // behavioural reference: decodes the serial line and tracks handshake timing
  always @(negedge clk) if (rst_n) begin
    if (sclk && prev_sclk) chk(sdo == prev_sdo, "R5", "sdo moved while clock high", sdo, prev_sdo);
    if (sclk && !prev_sclk) begin
      chk(low_run == DIV, "R5", "low half width", low_run, DIV);
      chk(cs, "R6", "clock rise inside select", cs, 1);
      acc = {acc[6:0], sdo};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", acc, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(acc == e, (frame_bytes == 0) ? "R1" : "R2", "byte value", acc, e);
        end
        frame_bytes++;
      end
    end
    if (!sclk && prev_sclk) chk(hi_run >= DIV, "R5", "high half width", hi_run, DIV);
    if (sclk) begin hi_run++; low_run = 0; end
    else begin low_run++; hi_run = 0; end

    if (cs && !prev_cs) begin frame_bytes = 0; bitn = 0; end
    if (!cs && prev_cs) begin
      int l;
      chk(bitn == 0, "R3", "partial byte at select fall", bitn, 0);
      chk(sclk, "R6", "clock high at select fall", sclk, 1);
      l = (len_q.size() != 0) ? len_q.pop_front() : -1;
      chk(frame_bytes == l, (l == 3) ? "R3" : "R4", "frame length", frame_bytes, l);
      done_due = (hold_q.size() != 0) ? hold_q.pop_front() : -1;
    end

    if (done_due == 0 || done) chk(done == (done_due == 0), "R7", "done timing", done, done_due == 0);
    chk(req_ready == (!cs && done_due <= 0), "R8", "req_ready", req_ready, !cs && done_due <= 0);
    if (chk_b2b) begin chk(cs, "R8", "select after same-cycle accept", cs, 1); chk_b2b = 1'b0; end
    if (done && req_valid && req_ready) chk_b2b = 1'b1;
    if (!cs) chk(!dat_ready, "R9", "dat_ready outside burst", dat_ready, 0);
    if (done_due >= 0) done_due--;
    prev_cs = cs; prev_sclk = sclk; prev_sdo = sdo;
  end

  task automatic push_frame(input logic rs, input logic [7:0] d[$], input int hus);
    exp_q.push_back(rs ? 8'hFA : 8'hF8);
    foreach (d[i]) begin
      exp_q.push_back({d[i][7:4], 4'h0});
      exp_q.push_back({d[i][3:0], 4'h0});
    end
    len_q.push_back(1 + 2 * d.size());
    hold_q.push_back(hus * CPU);
  endtask

  task automatic issue(input logic rs, input logic [7:0] c, input int hus);
    @(posedge clk); #2;
    req_valid = 1'b1; req_data = rs; req_cmd = c; req_hold = HUS'(hus);
    while (!req_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] c, input int hus);
    logic [7:0] d[$];
    d.push_back(c);
    push_frame(1'b0, d, hus);
    issue(1'b0, c, hus);
  endtask

  task automatic do_data(input logic [7:0] d[$], input int hus, input int stall);
    push_frame(1'b1, d, hus);
    issue(1'b1, 8'h00, hus);
    foreach (d[i]) begin
      repeat (stall) @(posedge clk);
      @(posedge clk); #2;
      dat_valid = 1'b1; dat_byte = d[i]; dat_last = (i == d.size() - 1);
      while (!dat_ready) begin @(posedge clk); #2; end
      @(posedge clk); #2;
      dat_valid = 1'b0; dat_last = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(!cs && sclk && !sdo, "R10", "serial pins in reset", {cs, sclk, sdo}, 3'b010);
    chk(req_ready && !dat_ready && !done, "R10", "handshake in reset", {req_ready, dat_ready, done}, 3'b100);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!cs && sclk && !sdo && req_ready && !dat_ready && !done, "R10", "after reset",
        {cs, sclk, sdo, req_ready, dat_ready, done}, 6'b010100);

    // R9: stream traffic while idle is not taken
    @(posedge clk); #2; dat_valid = 1'b1; dat_byte = 8'hA5; dat_last = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!cs && !dat_ready, "R9", "idle stream ignored", {cs, dat_ready}, 0);
    end
    @(posedge clk); #2; dat_valid = 1'b0; dat_last = 1'b0;

    do_cmd(8'h30, 72);     // R3, R7 nonzero hold
    do_cmd(8'h0C, 0);      // R8 same-cycle accept after hold
    do_cmd(8'h36, 3);      // R7 zero-hold predecessor
    do_cmd(8'h01, 1600);   // long hold
    d.delete();
    for (int i = 0; i < 16; i++) d.push_back(8'(i * 37 + 5));
    do_data(d, 72, 0);     // R4 16-byte burst
    d.delete(); d.push_back(8'h81);
    do_data(d, 0, 0);      // R4 single byte, zero hold
    d.delete(); d.push_back(8'h3C); d.push_back(8'hF0); d.push_back(8'h0F);
    do_data(d, 2, 5);      // R4 stalled stream
    do_cmd(8'hFF, 0);

    while (len_q.size() != 0 || done_due >= 0) @(posedge clk);
    repeat (5) @(posedge clk);
    chk(exp_q.size() == 0, "R4", "bytes left unsent", exp_q.size(), 0);
    chk(!cs && req_ready, "R8", "idle at end", {cs, req_ready}, 2'b01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule